// File: doc/BRIEF.md
# Rectangle Blit and Fill Engine

This block is a 2D raster engine for a linear frame buffer with 32 bits per pixel, where one memory word holds one pixel. Software programs source and destination surfaces, coordinates, an extent, a scan direction and a raster-op code through a small register port. A write to the height register starts the operation. The engine then either copies a rectangle from source to destination or fills the destination rectangle with a brush or palette colour. It works through a single-word synchronous memory port. Read data returns one cycle after the read strobe.

Before it touches memory, the engine rejects operations that are unsupported or that fall outside the frame buffer. Copies move one row at a time through an internal line buffer. If the vertical scan order matches the overlap, source and destination may overlap. When an operation succeeds, the engine advances the destination coordinate, so the next rectangle can follow on without being reprogrammed.

Top module: `rect_blit_engine`

## Requirements
- R1: The registers are selected by `regAddr`: 0 source pitch/offset, 1 destination pitch/offset, 2 default pitch/offset, 3 source position, 4 destination position (both as {Y[31:16], X[15:0]}), 5 width, 6 mix, 7 direction, 8 master control, 9 brush colour, 10 palette entry 0, 11 palette entry 1, 12 display byte offset, 13 height. A write to register 13 while idle starts an operation. `busy` is high from the next cycle until the last write. `done` pulses for one cycle as `busy` falls. Every register write made while `busy` is high is ignored.
- R2: A pitch/offset word carries the offset in bits 20:0, in units of 32 bytes (8 words), and the pitch in pixels in bits 29:21. Bit 31 has no effect. Bits 26:2 of the display byte offset are added to every base as a word offset.
- R3: Master bit 0 set selects the source and destination pitch/offset words. Bit 0 clear selects the default word for both.
- R4: Direction bit 0 set scans left to right and bit 1 set scans top to bottom. With a bit clear, the rectangle starts on that axis at coordinate + 1 − extent, for source and destination alike.
- R5: A copy gives the same result as reading the whole source into a temporary buffer and then writing it. This holds in all four directions, provided rows run top to bottom whenever the destination's first row is not below the source's.
- R6: The raster-op is mix bits 23:16. 0xCC copies. 0xF0 fills with the brush unchanged. 0x00 fills with {0xFF, palette 0 bits 23:0}. 0xFF fills with {0xFF, palette 1 bits 23:0}.
- R7: The engine rejects an operation when base + startX + (startY + height) × pitch is not below the frame buffer size in words. The destination is always checked, and for a copy the source is checked too. A rejected operation writes nothing, sets `errFlag` and completes with `done`.
- R8: Any other raster-op code completes at once with `errFlag` set and no memory access.
- R9: A copy wider than `LINE_WORDS` is rejected like R8.
- R10: After a successful copy, destination X increases by the width. After a successful fill, destination Y increases by the height. A rejected operation leaves both unchanged.
- R11: A zero width or height completes without memory access and without error. The R10 advance still applies.
- R12: `errFlag` is valid at `done` and stays valid until the next start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register index |
| regWdata | input | 32 | Register write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Last operation was rejected |
| dstXOut | output | 16 | Current destination X |
| dstYOut | output | 16 | Current destination Y |
| memAddr | output | ADDR_W | Word address |
| memRe | output | 1 | Read strobe |
| memWe | output | 1 | Write strobe |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, one cycle after memRe |

## Verification
The assertions take three things for granted. The memory answers every read exactly one cycle later. Register traffic arrives only through the write strobe. Every address issued comes from an operation that passed the bounds check. The bench memory is a registered array with that single-cycle latency, and inputs change only on falling edges. The bench programs overlapping copies only with a vertical order that matches the overlap. It also gives zero-size, oversize and out-of-range operations their own cases, so the in-range address property always sees an admitted rectangle.

// File: rtl/rect_blit_pkg.sv
package rect_blit_pkg;
  localparam logic [7:0] ROP_COPY  = 8'hCC;
  localparam logic [7:0] ROP_BRUSH = 8'hF0;
  localparam logic [7:0] ROP_BLACK = 8'h00;
  localparam logic [7:0] ROP_WHITE = 8'hFF;

  localparam logic [3:0] RA_SRC_PO  = 4'd0;
  localparam logic [3:0] RA_DST_PO  = 4'd1;
  localparam logic [3:0] RA_DEF_PO  = 4'd2;
  localparam logic [3:0] RA_SRC_XY  = 4'd3;
  localparam logic [3:0] RA_DST_XY  = 4'd4;
  localparam logic [3:0] RA_WIDTH   = 4'd5;
  localparam logic [3:0] RA_MIX     = 4'd6;
  localparam logic [3:0] RA_DIR     = 4'd7;
  localparam logic [3:0] RA_MASTER  = 4'd8;
  localparam logic [3:0] RA_BRUSH   = 4'd9;
  localparam logic [3:0] RA_PAL0    = 4'd10;
  localparam logic [3:0] RA_PAL1    = 4'd11;
  localparam logic [3:0] RA_DISP    = 4'd12;
  localparam logic [3:0] RA_HEIGHT  = 4'd13;

  typedef struct packed {
    logic load;
    logic rdEn;
    logic wrFill;
    logic wrCopy;
    logic colInc;
    logic rowInc;
    logic commit;
    logic fail;
    logic finish;
  } blitStrobe_t;
endpackage

// File: rtl/rect_blit_dp.sv
module rect_blit_dp
  import rect_blit_pkg::*;
#(
  parameter int FB_WORDS   = 4096,
  parameter int LINE_WORDS = 64,
  localparam int ADDR_W    = $clog2(FB_WORDS),
  localparam int LB_W      = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWdata,
  input  logic              busy,
  input  logic              done,
  input  blitStrobe_t       stb,
  output logic              trigger,
  output logic              isCopy,
  output logic              opErr,
  output logic              opEmpty,
  output logic              colLast,
  output logic              rowLast,
  output logic              errFlag,
  output logic [15:0]       dstXOut,
  output logic [15:0]       dstYOut,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata
);
  // configuration state
  logic [20:0] srcOff, dstOff, defOff;
  logic [8:0]  srcPitch, dstPitch, defPitch;
  logic [15:0] srcX, srcY, dstX, dstY, widthReg, heightReg;
  logic [7:0]  ropReg;
  logic [1:0]  dirReg;
  logic        usePerOp;
  logic [31:0] brushReg;
  logic [23:0] pal0Reg, pal1Reg;
  logic [24:0] dispWord;

  // walk state
  logic [15:0] col, row;
  logic [31:0] lineBuf [LINE_WORDS];
  logic        rdPend;
  logic [LB_W-1:0] rdIdx;

  logic writeOk;
  assign writeOk = regWe && !busy;
  assign trigger = writeOk && (regAddr == RA_HEIGHT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcOff <= '0; dstOff <= '0; defOff <= '0;
      srcPitch <= '0; dstPitch <= '0; defPitch <= '0;
      srcX <= '0; srcY <= '0; dstX <= '0; dstY <= '0;
      widthReg <= '0; heightReg <= '0; ropReg <= '0; dirReg <= '0;
      usePerOp <= 1'b0; brushReg <= '0; pal0Reg <= '0; pal1Reg <= '0;
      dispWord <= '0;
    end else begin
      if (writeOk) begin
        case (regAddr)
          RA_SRC_PO: begin srcOff <= regWdata[20:0]; srcPitch <= regWdata[29:21]; end
          RA_DST_PO: begin dstOff <= regWdata[20:0]; dstPitch <= regWdata[29:21]; end
          RA_DEF_PO: begin defOff <= regWdata[20:0]; defPitch <= regWdata[29:21]; end
          RA_SRC_XY: begin srcX <= regWdata[15:0]; srcY <= regWdata[31:16]; end
          RA_DST_XY: begin dstX <= regWdata[15:0]; dstY <= regWdata[31:16]; end
          RA_WIDTH:  widthReg <= regWdata[15:0];
          RA_MIX:    ropReg <= regWdata[23:16];
          RA_DIR:    dirReg <= regWdata[1:0];
          RA_MASTER: usePerOp <= regWdata[0];
          RA_BRUSH:  brushReg <= regWdata;
          RA_PAL0:   pal0Reg <= regWdata[23:0];
          RA_PAL1:   pal1Reg <= regWdata[23:0];
          RA_DISP:   dispWord <= regWdata[26:2];
          RA_HEIGHT: heightReg <= regWdata[15:0];
          default: ;
        endcase
      end
      if (stb.commit) begin
        if (isCopy) dstX <= dstX + widthReg;
        else        dstY <= dstY + heightReg;
      end
    end
  end

  assign dstXOut = dstX;
  assign dstYOut = dstY;

  // operation decode
  logic isFill, ltr, ttb;
  assign ltr    = dirReg[0];
  assign ttb    = dirReg[1];
  assign isCopy = (ropReg == ROP_COPY);
  assign isFill = (ropReg == ROP_BRUSH) || (ropReg == ROP_BLACK) || (ropReg == ROP_WHITE);

  // surface selection and start corners
  logic [20:0] selSrcOff, selDstOff;
  logic [8:0]  selSrcPitch, selDstPitch;
  assign selSrcOff   = usePerOp ? srcOff   : defOff;
  assign selDstOff   = usePerOp ? dstOff   : defOff;
  assign selSrcPitch = usePerOp ? srcPitch : defPitch;
  assign selDstPitch = usePerOp ? dstPitch : defPitch;

  logic [15:0] sX0, sY0, dX0, dY0;
  assign sX0 = ltr ? srcX : srcX + 16'd1 - widthReg;
  assign dX0 = ltr ? dstX : dstX + 16'd1 - widthReg;
  assign sY0 = ttb ? srcY : srcY + 16'd1 - heightReg;
  assign dY0 = ttb ? dstY : dstY + 16'd1 - heightReg;

  logic [31:0] srcBase, dstBase;
  assign srcBase = {8'd0, selSrcOff, 3'b000} + {7'd0, dispWord};
  assign dstBase = {8'd0, selDstOff, 3'b000} + {7'd0, dispWord};

  logic [31:0] srcLim, dstLim;
  logic boundsOk;
  assign srcLim = srcBase + {16'd0, sX0} + ({16'd0, sY0} + {16'd0, heightReg}) * {23'd0, selSrcPitch};
  assign dstLim = dstBase + {16'd0, dX0} + ({16'd0, dY0} + {16'd0, heightReg}) * {23'd0, selDstPitch};
  assign boundsOk = (dstLim < 32'(FB_WORDS)) && (!isCopy || (srcLim < 32'(FB_WORDS)));

  assign opEmpty = (widthReg == 16'd0) || (heightReg == 16'd0);
  assign opErr   = !(isCopy || isFill) || (isCopy && (widthReg > 16'(LINE_WORDS))) ||
                   (!opEmpty && !boundsOk);

  // rectangle walk counters
  assign colLast = (col == widthReg - 16'd1);
  assign rowLast = (row == heightReg - 16'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      col <= '0;
      row <= '0;
    end else if (stb.load) begin
      col <= '0;
      row <= '0;
    end else begin
      if (stb.colInc) col <= colLast ? 16'd0 : col + 16'd1;
      if (stb.rowInc) row <= row + 16'd1;
    end
  end

  logic [15:0] rowIdx, sRow, dRow;
  assign rowIdx = ttb ? row : heightReg - 16'd1 - row;
  assign sRow   = sY0 + rowIdx;
  assign dRow   = dY0 + rowIdx;

  logic [31:0] srcLin, dstLin;
  assign srcLin = srcBase + {16'd0, sRow} * {23'd0, selSrcPitch} + {16'd0, sX0} + {16'd0, col};
  assign dstLin = dstBase + {16'd0, dRow} * {23'd0, selDstPitch} + {16'd0, dX0} + {16'd0, col};

  // line buffer capture, one cycle behind the read strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend <= 1'b0;
      rdIdx  <= '0;
    end else begin
      rdPend <= stb.rdEn;
      rdIdx  <= col[LB_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rdPend) lineBuf[rdIdx] <= memRdata;
  end

  logic [31:0] fillColor;
  always_comb begin
    case (ropReg)
      ROP_BLACK: fillColor = {8'hFF, pal0Reg};
      ROP_WHITE: fillColor = {8'hFF, pal1Reg};
      default:   fillColor = brushReg;
    endcase
  end

  assign memRe    = stb.rdEn;
  assign memWe    = stb.wrFill || stb.wrCopy;
  assign memAddr  = stb.rdEn ? srcLin[ADDR_W-1:0] : dstLin[ADDR_W-1:0];
  assign memWdata = stb.wrCopy ? lineBuf[col[LB_W-1:0]] : fillColor;

  always_ff @(posedge clk) begin
    if (!rstN)          errFlag <= 1'b0;
    else if (trigger)   errFlag <= 1'b0;
    else if (stb.fail)  errFlag <= 1'b1;
  end

  // R1
  mem_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> busy);
  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(widthReg) && $stable(heightReg) && $stable(ropReg)));
  // R7
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> ((stb.rdEn ? srcLin : dstLin) < 32'(FB_WORDS)));
  // R10
  coord_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!$stable(dstX) || !$stable(dstY)) && $past(busy)) |-> done);
endmodule

// File: rtl/rect_blit_ctl.sv
module rect_blit_ctl
  import rect_blit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigger,
  input  logic        isCopy,
  input  logic        opErr,
  input  logic        opEmpty,
  input  logic        colLast,
  input  logic        rowLast,
  output blitStrobe_t stb,
  output logic        busy,
  output logic        done
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_FILL, S_READ, S_RWAIT, S_WRITE} state_t;
  state_t state, nextState;

  always_comb begin
    stb = '0;
    nextState = state;
    case (state)
      S_IDLE: if (trigger) nextState = S_CHECK;
      S_CHECK: begin
        if (opErr) begin
          stb.fail = 1'b1; stb.finish = 1'b1; nextState = S_IDLE;
        end else if (opEmpty) begin
          stb.commit = 1'b1; stb.finish = 1'b1; nextState = S_IDLE;
        end else begin
          stb.load = 1'b1;
          nextState = isCopy ? S_READ : S_FILL;
        end
      end
      S_FILL: begin
        stb.wrFill = 1'b1; stb.colInc = 1'b1;
        if (colLast) begin
          stb.rowInc = 1'b1;
          if (rowLast) begin
            stb.commit = 1'b1; stb.finish = 1'b1; nextState = S_IDLE;
          end
        end
      end
      S_READ: begin
        stb.rdEn = 1'b1; stb.colInc = 1'b1;
        if (colLast) nextState = S_RWAIT;
      end
      S_RWAIT: nextState = S_WRITE;
      S_WRITE: begin
        stb.wrCopy = 1'b1; stb.colInc = 1'b1;
        if (colLast) begin
          stb.rowInc = 1'b1;
          if (rowLast) begin
            stb.commit = 1'b1; stb.finish = 1'b1; nextState = S_IDLE;
          end else begin
            nextState = S_READ;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= stb.finish;
    end
  end

  assign busy = (state != S_IDLE);

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R1
  done_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  // R8
  reject_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && opErr) |=> (done && !busy));
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
  import rect_blit_pkg::*;
#(
  parameter int FB_WORDS   = 4096,
  parameter int LINE_WORDS = 64,
  localparam int ADDR_W    = $clog2(FB_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic              busy,
  output logic              done,
  output logic              errFlag,
  output logic [15:0]       dstXOut,
  output logic [15:0]       dstYOut,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata
);
  blitStrobe_t stb;
  logic trigger, isCopy, opErr, opEmpty, colLast, rowLast;

  rect_blit_ctl u_ctl (
    .clk(clk), .rstN(rstN), .trigger(trigger), .isCopy(isCopy), .opErr(opErr),
    .opEmpty(opEmpty), .colLast(colLast), .rowLast(rowLast), .stb(stb),
    .busy(busy), .done(done)
  );

  rect_blit_dp #(.FB_WORDS(FB_WORDS), .LINE_WORDS(LINE_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .busy(busy), .done(done), .stb(stb), .trigger(trigger), .isCopy(isCopy),
    .opErr(opErr), .opEmpty(opEmpty), .colLast(colLast), .rowLast(rowLast),
    .errFlag(errFlag), .dstXOut(dstXOut), .dstYOut(dstYOut), .memAddr(memAddr),
    .memRe(memRe), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata)
  );
endmodule

// File: tb/rect_blit_engine_test.sv
module rect_blit_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int FB = 1024;
  localparam int LW = 8;
  localparam int AW = $clog2(FB);

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic busy, done, errFlag, memRe, memWe;
  logic [15:0] dstXOut, dstYOut;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata, memRdata;

  logic [31:0] mem  [FB];
  logic [31:0] refm [FB];
  logic [31:0] tmp  [256];
  int total = 0, failed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rect_blit_engine #(.FB_WORDS(FB), .LINE_WORDS(LW)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .busy(busy), .done(done), .errFlag(errFlag), .dstXOut(dstXOut), .dstYOut(dstYOut),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
  end

  task automatic checkv(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic initMem(input int seed);
    for (int i = 0; i < FB; i++) begin
      mem[i]  = 32'h5A000000 ^ (32'(i) * 32'h00010003) ^ 32'(seed);
      refm[i] = mem[i];
    end
  endtask

  task automatic checkMem(input string tag);
    int bad = -1;
    for (int i = FB - 1; i >= 0; i--) if (mem[i] !== refm[i]) bad = i;
    if (bad < 0) checkv(tag, 32'd0, 32'd0);
    else checkv({tag, " word"}, mem[bad], refm[bad]);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  function automatic logic [31:0] po(input int off, input int p);
    return {2'b00, 9'(p), 21'(off)};
  endfunction

  task automatic waitDone();
    int n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n > 5000) begin
        checkv("R1 done timeout", 32'd0, 32'd1);
        break;
      end
    end
    checkv("R1 busy low with done", 32'(busy), 32'd0);
  endtask

  task automatic runOp(input int h);
    wreg(4'd13, 32'(h));
    checkv("R1 busy after start", 32'(busy), 32'd1);
    waitDone();
  endtask

  task automatic refCopy(input int sb, input int sp, input int sx, input int sy,
                         input int db, input int dp, input int dx, input int dy,
                         input int w, input int h);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) tmp[r*16+c] = refm[sb + (sy+r)*sp + sx + c];
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) refm[db + (dy+r)*dp + dx + c] = tmp[r*16+c];
  endtask

  task automatic refFill(input int db, input int dp, input int dx, input int dy,
                         input int w, input int h, input logic [31:0] v);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) refm[db + (dy+r)*dp + dx + c] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checkv("watchdog expired", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int wl [3] = '{1, 3, 8};
    int hl [2] = '{1, 3};
    initMem(0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkv("R1 reset busy", 32'(busy), 32'd0);
    checkv("R1 reset done", 32'(done), 32'd0);
    checkv("R12 reset err", 32'(errFlag), 32'd0);
    checkv("R10 reset X", 32'(dstXOut), 32'd0);

    // R4 R5 R2: copy sweep over directions and sizes, tile bit set on source word
    for (int dir = 0; dir < 4; dir++)
      for (int wi = 0; wi < 3; wi++)
        for (int hi = 0; hi < 2; hi++) begin
          int w = wl[wi], h = hl[hi];
          int ltr = dir & 1, ttb = (dir >> 1) & 1;
          int sxT = 4, syT = 4, dxT, dyT, px, py, qx, qy;
          dxT = ltr ? 6 : 2;
          dyT = ttb ? 3 : 5;
          px = ltr ? sxT : sxT + w - 1; py = ttb ? syT : syT + h - 1;
          qx = ltr ? dxT : dxT + w - 1; qy = ttb ? dyT : dyT + h - 1;
          initMem(dir * 97 + w * 7 + h);
          refCopy(0, 32, sxT, syT, 0, 32, dxT, dyT, w, h);
          wreg(4'd0, po(0, 32) | 32'h80000000);
          wreg(4'd1, po(0, 32));
          wreg(4'd3, {16'(py), 16'(px)});
          wreg(4'd4, {16'(qy), 16'(qx)});
          wreg(4'd5, 32'(w));
          wreg(4'd6, 32'h00CC0000);
          wreg(4'd7, 32'(dir));
          wreg(4'd8, 32'd1);
          wreg(4'd12, 32'd0);
          runOp(h);
          checkMem($sformatf("R5 R4 copy dir=%0d w=%0d h=%0d", dir, w, h));
          checkv("R12 copy err clear", 32'(errFlag), 32'd0);
          checkv("R10 copy X advance", 32'(dstXOut), 32'(qx + w));
          checkv("R10 copy Y kept", 32'(dstYOut), 32'(qy));
        end

    // R2: separate surfaces, offset field and display offset
    initMem(11);
    refCopy(16, 32, 1, 2, 128 + 16, 20, 3, 4, 5, 2);
    wreg(4'd0, po(0, 32)); wreg(4'd1, po(16, 20));
    wreg(4'd3, {16'd2, 16'd1}); wreg(4'd4, {16'd4, 16'd3});
    wreg(4'd5, 32'd5); wreg(4'd7, 32'd3); wreg(4'd12, 32'd64);
    runOp(2);
    checkMem("R2 offsets and display offset");

    // R6 R3: brush fill via default surface, right-to-left bottom-to-top start
    initMem(12);
    refFill(32 + 16, 16, 4, 9, 4, 2, 32'h12345678);
    wreg(4'd2, po(4, 16)); wreg(4'd8, 32'd0); wreg(4'd7, 32'd0);
    wreg(4'd4, {16'd10, 16'd7}); wreg(4'd5, 32'd4);
    wreg(4'd6, 32'h00F00000); wreg(4'd9, 32'h12345678);
    runOp(2);
    checkMem("R6 R3 R4 brush fill default surface");
    checkv("R10 fill Y advance", 32'(dstYOut), 32'd12);
    checkv("R10 fill X kept", 32'(dstXOut), 32'd7);

    // R6: palette fills
    initMem(13);
    refFill(0, 32, 2, 1, 3, 3, 32'hFF112233);
    wreg(4'd1, po(0, 32)); wreg(4'd8, 32'd1); wreg(4'd12, 32'd0); wreg(4'd7, 32'd3);
    wreg(4'd4, {16'd1, 16'd2}); wreg(4'd5, 32'd3);
    wreg(4'd6, 32'h00000000); wreg(4'd10, 32'hAB112233);
    runOp(3);
    checkMem("R6 black fill");
    refFill(0, 32, 2, 4, 3, 1, 32'hFF445566);
    wreg(4'd6, 32'h00FF0000); wreg(4'd11, 32'h00445566);
    runOp(1);
    checkMem("R6 white fill continues at advanced Y");
    checkv("R10 second fill Y", 32'(dstYOut), 32'd5);

    // R1: writes while busy are ignored
    initMem(14);
    refFill(0, 32, 0, 20, 8, 3, 32'hCAFEF00D);
    wreg(4'd4, {16'd20, 16'd0}); wreg(4'd5, 32'd8);
    wreg(4'd6, 32'h00F00000); wreg(4'd9, 32'hCAFEF00D);
    wreg(4'd13, 32'd3);
    wreg(4'd5, 32'd2); wreg(4'd9, 32'h0); wreg(4'd13, 32'd9);
    waitDone();
    checkMem("R1 fill with busy-time writes");
    checkv("R1 Y after busy writes", 32'(dstYOut), 32'd23);
    refFill(0, 32, 0, 23, 8, 1, 32'hCAFEF00D);
    runOp(1);
    checkMem("R1 width and brush kept from before busy");

    // R7: destination out of range
    initMem(15);
    wreg(4'd4, {16'd40, 16'd0}); wreg(4'd5, 32'd2);
    runOp(2);
    checkv("R7 dest bounds err", 32'(errFlag), 32'd1);
    checkMem("R7 nothing written");
    checkv("R10 Y unchanged on reject", 32'(dstYOut), 32'd40);
    // R7 R12: source out of range on copy, then error cleared by good op
    wreg(4'd0, po(0, 32)); wreg(4'd3, {16'd30, 16'd0});
    wreg(4'd4, {16'd1, 16'd0}); wreg(4'd6, 32'h00CC0000);
    runOp(3);
    checkv("R7 source bounds err", 32'(errFlag), 32'd1);
    checkMem("R7 copy nothing written");
    checkv("R10 X unchanged on reject", 32'(dstXOut), 32'd0);
    // R8: unsupported code
    wreg(4'd6, 32'h00550000); wreg(4'd3, {16'd0, 16'd0});
    runOp(1);
    checkv("R8 bad rop err", 32'(errFlag), 32'd1);
    checkMem("R8 no write");
    // R9: copy wider than the line buffer
    wreg(4'd6, 32'h00CC0000); wreg(4'd5, 32'(LW + 1));
    runOp(1);
    checkv("R9 wide copy err", 32'(errFlag), 32'd1);
    checkMem("R9 no write");
    // R11 R12: zero height fill, error cleared
    wreg(4'd6, 32'h00F00000); wreg(4'd4, {16'd6, 16'd5}); wreg(4'd5, 32'd4);
    runOp(0);
    checkv("R12 err cleared", 32'(errFlag), 32'd0);
    checkMem("R11 zero height no write");
    checkv("R11 Y plus zero", 32'(dstYOut), 32'd6);
    // R11: zero width copy advances X by zero
    wreg(4'd6, 32'h00CC0000); wreg(4'd5, 32'd0);
    runOp(2);
    checkv("R11 zero width no err", 32'(errFlag), 32'd0);
    checkv("R11 X plus zero", 32'(dstXOut), 32'd5);
    checkMem("R11 zero width no write");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule